// File: doc/BRIEF.md
# Graphic LCD Host Bus Front End

This block sits between a host processor and the core of a graphic LCD controller. It accepts byte transfers over an 8-bit parallel bus or over a two-wire serial link. Each completed write becomes a one-cycle strobe carrying the byte and a tag that marks it as an instruction or as display data. A static pin picks parallel or serial operation. In parallel operation a second static pin picks the bus timing: enable plus read/write direction, or separate active-low read and write strobes.

The host pins are asynchronous to the controller clock. They pass through a synchronizer chain, and the block then detects strobe edges in the controller clock domain. On parallel reads the block drives the data bus with a status byte or with RAM read data supplied by the core. The status byte carries the core busy flag in its top bit. In serial operation the bus is never driven.

The core can clear the serial receiver with a pulse, for example when it executes a software reset.

Top module: `lcd_host_if`

## Requirements
- R1: A transfer is taken only while `cs1_n` is 0 and `cs2` is 1. Write strobes and read requests outside that window produce no `wr_stb` and no `d_oe`.
- R2: `wr_is_data` is 1 when `a0` was 1 during the transfer (display data) and 0 when `a0` was 0 (instruction).
- R3: With `par_sel`=1 and `bus68_sel`=0, a rising edge of `wr_rw` (active-low write) emits one `wr_stb` with `wr_byte` equal to `d_in`.
- R4: With `par_sel`=1 and `bus68_sel`=1, a falling edge of `rd_e` (active-high enable) emits one `wr_stb` while `wr_rw`=0. With `wr_rw`=1 the same edge emits nothing.
- R5: With `par_sel`=0, `d_in[7]` is sampled on each rising edge of `d_in[6]`, MSB first. The 8th rising edge emits one `wr_stb` whose byte holds the first bit in bit 7 and the last bit in bit 0.
- R6: A deselect (R1 window left) between serial edges discards the partial byte; the next byte starts from bit 7.
- R7: A `sif_clr` pulse discards a partial serial byte; the next byte starts from bit 7.
- R8: A parallel read drives `d_oe`=1. In the 80 timing this is while `rd_e`=0; in the 68 timing it is while `rd_e`=1 and `wr_rw`=1. With `a0`=0, `d_out` is the status byte {`core_busy`, 7'b0}. With `a0`=1, `d_out` is `rd_data`.
- R9: While `core_busy`=1, writes in both modes give no `wr_stb` and data reads leave `d_oe`=0. Status reads are still driven, and show bit 7 = 1.
- R10: With `par_sel`=0, `d_oe` stays 0 and toggling `rd_e` and `wr_rw` produces no `wr_stb`.
- R11: After reset `wr_stb` and `d_oe` are 0. Each strobe lasts one cycle and appears on the third clock edge after the pin edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 = parallel bus, 0 = serial link (static) |
| bus68_sel | input | 1 | 1 = enable+direction timing, 0 = separate read/write strobes (static) |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| a0 | input | 1 | 1 = display data, 0 = instruction/status |
| rd_e | input | 1 | Active-low read (80 timing) or active-high enable (68 timing) |
| wr_rw | input | 1 | Active-low write (80 timing) or direction, 1 = read (68 timing) |
| d_in | input | 8 | Bus input; serial data on bit 7, serial clock on bit 6 |
| d_out | output | 8 | Bus output value |
| d_oe | output | 1 | Bus output enable |
| core_busy | input | 1 | Core busy flag |
| rd_data | input | 8 | RAM read data from the core |
| sif_clr | input | 1 | Clears the serial receiver |
| wr_stb | output | 1 | One-cycle received-byte strobe |
| wr_byte | output | 8 | Received byte |
| wr_is_data | output | 1 | Tag of the received byte |

## Verification
The bench aims at the edge each timing style writes on. It uses a write in the 68 timing with the direction held at read, and a chip select missing on only one of its two pins. A design that latched on the wrong edge or decoded only one select pin would emit stray bytes.

Serial bytes are cut short by a deselect and by a clear pulse, then followed by a full byte. A receiver that failed to restart would deliver a rotated value.

Reads are tried with the core busy. A design that gated status reads or drove data reads there would show a wrong enable or a wrong top bit. The bench also toggles the read and write pins in serial mode, where any drive or strobe is an error.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int BYTE_W      = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic              cs1_n;
    logic              cs2;
    logic              a0;
    logic              rd_e;
    logic              wr_rw;
    logic [BYTE_W-1:0] d;
  } host_pins_t;
endpackage

// File: rtl/lcd_pin_sync.sv
module lcd_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[0] <= '0;
          else        st[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= '0;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/lcd_par_port.sv
module lcd_par_port
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              mode68,
  input  logic              a0,
  input  logic              rde,
  input  logic              wrrw,
  input  logic [BYTE_W-1:0] d,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              stb,
  output logic [BYTE_W-1:0] wbyte,
  output logic              wdata,
  output logic              oe,
  output logic [BYTE_W-1:0] dout
);
  logic              rde_q, wrrw_q;
  logic              stb_q, stb_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              data_q, data_n;
  logic              oe_q, oe_n;
  logic [BYTE_W-1:0] dout_q, dout_n;
  logic              wr_edge, rd_act;

  always_comb begin
    wr_edge = mode68 ? (!rde && rde_q && !wrrw) : (wrrw && !wrrw_q);
    rd_act  = mode68 ? (rde && wrrw) : !rde;
    stb_n   = sel && wr_edge && !busy;
    byte_n  = byte_q;
    data_n  = data_q;
    if (stb_n) begin
      byte_n = d;
      data_n = a0;
    end
    oe_n   = sel && rd_act && !(a0 && busy);
    dout_n = a0 ? rd_data : {busy, {(BYTE_W-1){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rde_q  <= 1'b0;
      wrrw_q <= 1'b0;
      stb_q  <= 1'b0;
      byte_q <= '0;
      data_q <= 1'b0;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      rde_q  <= rde;
      wrrw_q <= wrrw;
      stb_q  <= stb_n;
      byte_q <= byte_n;
      data_q <= data_n;
      oe_q   <= oe_n;
      if (oe_n) dout_q <= dout_n;
    end
  end

  assign stb   = stb_q;
  assign wbyte = byte_q;
  assign wdata = data_q;
  assign oe    = oe_q;
  assign dout  = dout_q;

  // R11: a parallel strobe is a single-cycle pulse
  p_par_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/lcd_ser_port.sv
module lcd_ser_port
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              a0,
  input  logic              busy,
  input  logic              clr,
  output logic              stb,
  output logic [BYTE_W-1:0] wbyte,
  output logic              wdata
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              stb_q, stb_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic              data_q, data_n;
  logic              rise;

  always_comb begin
    rise   = sclk && !sclk_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    stb_n  = 1'b0;
    byte_n = byte_q;
    data_n = data_q;
    if (clr) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (!en || !sel) begin
      cnt_n = '0;
    end else if (rise) begin
      if (cnt_q == LAST) begin
        cnt_n = '0;
        if (!busy) begin
          stb_n  = 1'b1;
          byte_n = {sh_q, sdin};
          data_n = a0;
        end
      end else begin
        sh_n  = {sh_q[BYTE_W-3:0], sdin};
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
      byte_q <= '0;
      data_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      stb_q  <= stb_n;
      byte_q <= byte_n;
      data_q <= data_n;
    end
  end

  assign stb   = stb_q;
  assign wbyte = byte_q;
  assign wdata = data_q;

  // R5: serial strobes are single-cycle pulses
  p_ser_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              bus68_sel,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              a0,
  input  logic              rd_e,
  input  logic              wr_rw,
  input  logic [BYTE_W-1:0] d_in,
  output logic [BYTE_W-1:0] d_out,
  output logic              d_oe,
  input  logic              core_busy,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              sif_clr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_is_data
);
  host_pins_t        raw, syn;
  logic              sel_s;
  logic              p_stb, p_data, p_oe;
  logic [BYTE_W-1:0] p_byte, p_dout;
  logic              s_stb, s_data;
  logic [BYTE_W-1:0] s_byte;

  assign raw = '{cs1_n: cs1_n, cs2: cs2, a0: a0, rd_e: rd_e, wr_rw: wr_rw, d: d_in};

  lcd_pin_sync #(.W($bits(host_pins_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(raw), .q(syn)
  );

  assign sel_s = !syn.cs1_n && syn.cs2;

  lcd_par_port u_par (
    .clk(clk), .rst_n(rst_n), .sel(sel_s), .mode68(bus68_sel), .a0(syn.a0),
    .rde(syn.rd_e), .wrrw(syn.wr_rw), .d(syn.d), .busy(core_busy),
    .rd_data(rd_data), .stb(p_stb), .wbyte(p_byte), .wdata(p_data),
    .oe(p_oe), .dout(p_dout)
  );

  lcd_ser_port u_ser (
    .clk(clk), .rst_n(rst_n), .en(!par_sel), .sel(sel_s),
    .sclk(syn.d[BYTE_W-2]), .sdin(syn.d[BYTE_W-1]), .a0(syn.a0),
    .busy(core_busy), .clr(sif_clr), .stb(s_stb), .wbyte(s_byte),
    .wdata(s_data)
  );

  assign wr_stb     = par_sel ? p_stb  : s_stb;
  assign wr_byte    = par_sel ? p_byte : s_byte;
  assign wr_is_data = par_sel ? p_data : s_data;
  assign d_oe       = par_sel && p_oe;
  assign d_out      = p_dout;

  // R10: serial operation never drives the bus
  p_serial_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !par_sel |-> !d_oe);

  // R9: no byte leaves the block in the cycle after the core was busy
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(core_busy));

  // R1: the bus is only driven when the synchronized select was active
  p_oe_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> $past(sel_s));
endmodule

// File: tb/lcd_host_if_test.sv
`timescale 1ns/1ps
module lcd_host_if_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_sel = 1'b1, bus68_sel = 1'b0;
  logic       cs1_n = 1'b1, cs2 = 1'b0, a0 = 1'b0;
  logic       rd_e = 1'b1, wr_rw = 1'b1;
  logic [7:0] d_in = 8'h00;
  logic [7:0] d_out;
  logic       d_oe;
  logic       core_busy = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       sif_clr = 1'b0;
  logic       wr_stb;
  logic [7:0] wr_byte;
  logic       wr_is_data;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  logic [8:0] got[$];

  always #5 clk = ~clk;

  lcd_host_if uut (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .bus68_sel(bus68_sel),
    .cs1_n(cs1_n), .cs2(cs2), .a0(a0), .rd_e(rd_e), .wr_rw(wr_rw),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .core_busy(core_busy),
    .rd_data(rd_data), .sif_clr(sif_clr), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .wr_is_data(wr_is_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: pin history plus a bit accumulator
  logic [12:0] p1, p2, p3, cur;
  bit   e_stb, e_dat, e_oe;
  logic [7:0] e_byte, e_dout;
  int   m_cnt, m_acc;
  always @(posedge clk) begin
    bit sel, wedge, ra;
    cur = {cs1_n, cs2, a0, rd_e, wr_rw, d_in};
    if (!rst_n) begin
      p1 = '0; p2 = '0; p3 = '0;
      e_stb = 0; e_oe = 0; m_cnt = 0; m_acc = 0;
    end else begin
      sel = !p2[12] && p2[11];
      e_stb = 0; e_oe = 0;
      if (sif_clr || par_sel || !sel) m_cnt = 0;
      if (par_sel) begin
        wedge = bus68_sel ? (!p2[9] && p3[9] && !p2[8]) : (p2[8] && !p3[8]);
        if (sel && wedge && !core_busy) begin
          e_stb = 1; e_byte = p2[7:0]; e_dat = p2[10];
        end
        ra = bus68_sel ? (p2[9] && p2[8]) : !p2[9];
        if (sel && ra && !(p2[10] && core_busy)) begin
          e_oe = 1; e_dout = p2[10] ? rd_data : {core_busy, 7'b0};
        end
      end else if (!sif_clr && sel && p2[6] && !p3[6]) begin
        m_acc = ((m_acc << 1) | int'(p2[7])) & 255;
        if (m_cnt == 7) begin
          m_cnt = 0;
          if (!core_busy) begin
            e_stb = 1; e_byte = 8'(m_acc); e_dat = p2[10];
          end
        end else m_cnt++;
      end
      p3 = p2; p2 = p1; p1 = cur;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_stb == e_stb, cur_req, "strobe vs model", wr_stb, e_stb);
      if (e_stb && wr_stb)
        check({wr_is_data, wr_byte} == {e_dat, e_byte}, cur_req,
              "byte vs model", {wr_is_data, wr_byte}, {e_dat, e_byte});
      check(d_oe == e_oe, cur_req, "oe vs model", d_oe, e_oe);
      if (e_oe && d_oe)
        check(d_out == e_dout, cur_req, "dout vs model", d_out, e_dout);
      if (wr_stb) got.push_back({wr_is_data, wr_byte});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_one(input string req, input logic [8:0] exp);
    check(got.size() == 1, req, "byte count", got.size(), 1);
    if (got.size() >= 1) check(got[0] == exp, req, "captured byte", got[0], exp);
    got.delete();
  endtask

  task automatic expect_none(input string req);
    check(got.size() == 0, req, "no byte", got.size(), 0);
    got.delete();
  endtask

  task automatic wr80(input bit isd, input logic [7:0] v);
    a0 = isd; d_in = v; tick(2);
    wr_rw = 1'b0; tick(3);
    wr_rw = 1'b1; tick(5);
  endtask

  task automatic wr68(input bit rw, input bit isd, input logic [7:0] v);
    wr_rw = rw; a0 = isd; d_in = v; tick(2);
    rd_e = 1'b1; tick(3);
    rd_e = 1'b0; tick(5);
  endtask

  task automatic ser_bits(input logic [7:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      d_in[7] = v[7-i]; d_in[6] = 1'b0; tick(2);
      d_in[6] = 1'b1; tick(2);
    end
    d_in[6] = 1'b0; tick(5);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    check(wr_stb == 1'b0, "R11", "reset strobe", wr_stb, 0);
    check(d_oe == 1'b0, "R11", "reset oe", d_oe, 0);
    rst_n = 1'b1; tick(4);

    // 80 timing writes
    cur_req = "R3"; cs1_n = 1'b0; cs2 = 1'b1; tick(3);
    wr80(1'b0, 8'h3C); expect_one("R3", {1'b0, 8'h3C});
    cur_req = "R2"; wr80(1'b1, 8'hA5); expect_one("R2", {1'b1, 8'hA5});

    // select window
    cur_req = "R1"; cs2 = 1'b0; tick(3); wr80(1'b0, 8'h11); expect_none("R1");
    cs1_n = 1'b1; cs2 = 1'b1; tick(3); wr80(1'b0, 8'h22); expect_none("R1");
    rd_e = 1'b0; tick(5);
    check(d_oe == 1'b0, "R1", "read while deselected", d_oe, 0);
    rd_e = 1'b1; tick(3);

    // reads in 80 timing
    cur_req = "R8"; cs1_n = 1'b0; a0 = 1'b0; rd_data = 8'h77; tick(3);
    rd_e = 1'b0; tick(5);
    check(d_oe && d_out == 8'h00, "R8", "status idle", {d_oe, d_out}, 9'h100);
    cur_req = "R9"; core_busy = 1'b1; tick(4);
    check(d_oe && d_out == 8'h80, "R9", "status busy", {d_oe, d_out}, 9'h180);
    a0 = 1'b1; tick(5);
    check(d_oe == 1'b0, "R9", "data read while busy", d_oe, 0);
    cur_req = "R8"; core_busy = 1'b0; tick(5);
    check(d_oe && d_out == 8'h77, "R8", "data read", {d_oe, d_out}, 9'h177);
    rd_e = 1'b1; tick(5);
    check(d_oe == 1'b0, "R8", "read released", d_oe, 0);

    // busy blocks writes
    cur_req = "R9"; core_busy = 1'b1; tick(2);
    wr80(1'b0, 8'h5E); expect_none("R9");
    core_busy = 1'b0; tick(2);

    // 68 timing
    cur_req = "R4"; cs1_n = 1'b1; tick(3); bus68_sel = 1'b1; rd_e = 1'b0; tick(4);
    cs1_n = 1'b0; tick(3);
    wr68(1'b0, 1'b1, 8'h5A); expect_one("R4", {1'b1, 8'h5A});
    wr68(1'b1, 1'b0, 8'hC7); expect_none("R4");
    cur_req = "R8"; a0 = 1'b1; rd_data = 8'h3E; wr_rw = 1'b1; tick(2); rd_e = 1'b1; tick(5);
    check(d_oe && d_out == 8'h3E, "R8", "68 data read", {d_oe, d_out}, 9'h13E);
    rd_e = 1'b0; tick(5);
    cur_req = "R9"; core_busy = 1'b1; tick(2);
    wr68(1'b0, 1'b0, 8'h44); expect_none("R9");
    core_busy = 1'b0; tick(2);

    // serial operation
    cur_req = "R5"; cs1_n = 1'b1; tick(3); par_sel = 1'b0; d_in = 8'h00; tick(4);
    cs1_n = 1'b0; a0 = 1'b1; tick(3);
    ser_bits(8'hC3, 8); expect_one("R5", {1'b1, 8'hC3});
    a0 = 1'b0; ser_bits(8'h01, 8); expect_one("R5", {1'b0, 8'h01});

    cur_req = "R10"; bus68_sel = 1'b0;
    rd_e = 1'b0; wr_rw = 1'b0; tick(5);
    check(d_oe == 1'b0, "R10", "serial read attempt", d_oe, 0);
    rd_e = 1'b1; wr_rw = 1'b1; tick(3); wr_rw = 1'b0; tick(3); wr_rw = 1'b1; tick(5);
    expect_none("R10");

    cur_req = "R6"; ser_bits(8'hE0, 3);
    cs1_n = 1'b1; tick(4); cs1_n = 1'b0; tick(3);
    ser_bits(8'h96, 8); expect_one("R6", {1'b0, 8'h96});

    cur_req = "R7"; ser_bits(8'hF8, 5);
    sif_clr = 1'b1; tick(1); sif_clr = 1'b0; tick(2);
    ser_bits(8'h2D, 8); expect_one("R7", {1'b0, 8'h2D});

    cur_req = "R9"; core_busy = 1'b1; ser_bits(8'h55, 8); expect_none("R9");
    core_busy = 1'b0; tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule